// File: doc/BRIEF.md
# Idle-Detect Standby Power Controller

This controller decides whether a logic core is active or asleep. It watches a vector of asynchronous input and I/O lines. Each line passes through a two-flop synchroniser, and then a qualification filter that accepts a change only if the new level holds for a minimum number of clocks. The block runs in one of two variants, picked by the `pinMode` input. In activity mode it drops into standby once a programmable number of clocks passes with no qualified change, and it wakes on the next qualified change. In pin mode a dedicated active-high power-down input, filtered to minimum high and low widths, forces standby while it is held high, and the data lines have no effect on the state.

When the core sleeps, an input gate holds the value presented to the core (`coreIn`) and a clock gate is closed. Waking happens in stages. The input gate opens first, the clock gate opens next, and the output-valid flag rises last. Each stage has its own programmable latency counted from the start of the wake.

Top module: `sbyc_top`

## Requirements
- R1: After reset the block is active: `standby`=0, `inGateEn`=1, `clkGateEn`=1, `outValid`=1, and `coreIn` is all zeros.
- R2: In activity mode (`pinMode`=0), with no qualified change since the block became active, `standby` rises at the IDLE_CYC+1-th rising clock edge after the block became active, and not before.
- R3: A change on a `dIn` bit counts as a qualified change only if the new level is held for at least QUAL_CYC clocks. A shorter pulse neither wakes the block from standby nor restarts the idle count.
- R4: In activity mode, a qualified change while active restarts the idle count. `standby` then rises IDLE_CYC+QUAL_CYC+3 clocks after the input changed.
- R5: In activity mode, a qualified change during standby starts a wake. `standby` falls QUAL_CYC+2 clocks after the input changed.
- R6: The wake starts when `standby` falls. `inGateEn` rises IN_WAKE clocks after that, `clkGateEn` rises CLK_WAKE clocks after it, and `outValid` rises OUT_WAKE clocks after it (IN_WAKE < CLK_WAKE < OUT_WAKE). No output-valid or clock gate is ever raised ahead of the stage before it.
- R7: While `inGateEn` is 0, `coreIn` holds its value. While `inGateEn` is 1, `coreIn` follows the synchronised `dIn` one clock after the synchroniser, that is, three clocks after a change on the pin.
- R8: In pin mode, a `pdPin` high level held for PD_HI_CYC clocks raises `standby` PD_HI_CYC+3 clocks after the rise. A shorter high pulse has no effect.
- R9: In pin mode, a `pdPin` low level held for PD_LO_CYC clocks during standby starts the wake PD_LO_CYC+3 clocks after the fall, with the staged timing of R6.
- R10: In pin mode, changes on `dIn` and the idle timeout never change the state. `pdPin` never reaches `coreIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinMode | input | 1 | 0 = activity mode, 1 = dedicated power-down pin mode |
| pdPin | input | 1 | Asynchronous active-high power-down request |
| dIn | input | NUM_IN | Monitored asynchronous inputs |
| standby | output | 1 | Core is in standby |
| inGateEn | output | 1 | Input changes pass to the core |
| clkGateEn | output | 1 | Core clock is enabled |
| outValid | output | 1 | Core outputs are valid |
| coreIn | output | NUM_IN | Gated input value presented to the core |

## Verification
The hardest situation to reach is a short pulse. It must be long enough to get through the synchroniser, but one clock short of qualifying. Such a pulse has to be shown to change nothing, both during standby, where it must not wake the block, and during activity, where it must not restart the idle count. The stimulus drives pulses of exactly QUAL_CYC-1 clocks at both points. It then checks the standby entry at the exact edge predicted from the last qualified change, so a glitch that was wrongly counted would move the entry visibly. The same pulse-width boundary is applied to `pdPin` at PD_HI_CYC-1 clocks.

// File: rtl/sbyc_pkg.sv
package sbyc_pkg;
  typedef enum logic [1:0] {ST_ACT, ST_SBY, ST_WAKE} sbyState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idleClr;
    logic passIn;
  } ctrlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic anyQual;
    logic idleDone;
    logic pdHigh;
  } dpStat_t;
endpackage

// File: rtl/sbyc_datapath.sv
module sbyc_datapath
  import sbyc_pkg::*;
#(
  parameter int NUM_IN    = 8,
  parameter int QUAL_CYC  = 3,
  parameter int IDLE_CYC  = 30,
  parameter int PD_HI_CYC = 8,
  parameter int PD_LO_CYC = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] dIn,
  input  logic              pdPin,
  input  ctrlStrb_t         strb,
  output dpStat_t           stat,
  output logic [NUM_IN-1:0] coreIn
);
  localparam int QW     = $clog2(QUAL_CYC + 1);
  localparam int IW     = $clog2(IDLE_CYC + 1);
  localparam int PD_MAX = (PD_HI_CYC > PD_LO_CYC) ? PD_HI_CYC : PD_LO_CYC;
  localparam int PW     = $clog2(PD_MAX + 1);

  logic [NUM_IN-1:0] syncA, syncB, filt, qual;
  logic [IW-1:0]     idleCnt;
  logic              pdA, pdB, pdFilt, pdQual;
  logic [PW-1:0]     pdCnt, pdLim;

  // two-flop synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      pdA   <= 1'b0;
      pdB   <= 1'b0;
    end else begin
      syncA <= dIn;
      syncB <= syncA;
      pdA   <= pdPin;
      pdB   <= pdA;
    end
  end

  // per-bit pulse qualification
  for (genvar i = 0; i < NUM_IN; i++) begin : gBit
    logic [QW-1:0] runCnt;
    assign qual[i] = (syncB[i] != filt[i]) && (runCnt == QW'(QUAL_CYC - 1));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt  <= '0;
        filt[i] <= 1'b0;
      end else if (syncB[i] != filt[i]) begin
        if (qual[i]) begin
          filt[i] <= syncB[i];
          runCnt  <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  // power-down pin width filter
  assign pdLim  = pdFilt ? PW'(PD_LO_CYC - 1) : PW'(PD_HI_CYC - 1);
  assign pdQual = (pdB != pdFilt) && (pdCnt == pdLim);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdCnt  <= '0;
      pdFilt <= 1'b0;
    end else if (pdB != pdFilt) begin
      if (pdQual) begin
        pdFilt <= pdB;
        pdCnt  <= '0;
      end else begin
        pdCnt <= pdCnt + 1'b1;
      end
    end else begin
      pdCnt <= '0;
    end
  end

  // idle timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strb.idleClr || stat.anyQual) begin
      idleCnt <= '0;
    end else if (idleCnt != IW'(IDLE_CYC)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // input gate towards the core
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreIn <= '0;
    end else if (strb.passIn) begin
      coreIn <= syncB;
    end
  end

  assign stat.anyQual  = |qual;
  assign stat.idleDone = (idleCnt == IW'(IDLE_CYC));
  assign stat.pdHigh   = pdFilt;

  AST_CORE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.passIn |=> $stable(coreIn)); // R7
  AST_PD_RISE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdFilt) |-> $past(pdB)); // R8
endmodule

// File: rtl/sbyc_control.sv
module sbyc_control
  import sbyc_pkg::*;
#(
  parameter int IN_WAKE  = 4,
  parameter int CLK_WAKE = 6,
  parameter int OUT_WAKE = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pinMode,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      standby,
  output logic      inGateEn,
  output logic      clkGateEn,
  output logic      outValid
);
  localparam int WW = $clog2(OUT_WAKE + 1);

  sbyState_t     state, nextState;
  logic [WW-1:0] wakeCnt;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_ACT:  if (pinMode ? stat.pdHigh : stat.idleDone) nextState = ST_SBY;
      ST_SBY:  if (pinMode ? !stat.pdHigh : stat.anyQual) nextState = ST_WAKE;
      ST_WAKE: begin
        if (pinMode && stat.pdHigh)                 nextState = ST_SBY;
        else if (wakeCnt == WW'(OUT_WAKE - 1))      nextState = ST_ACT;
      end
      default: nextState = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_ACT;
      wakeCnt <= '0;
    end else begin
      state   <= nextState;
      wakeCnt <= (state == ST_WAKE) ? wakeCnt + 1'b1 : '0;
    end
  end

  assign standby   = (state == ST_SBY);
  assign outValid  = (state == ST_ACT);
  assign inGateEn  = outValid || ((state == ST_WAKE) && (wakeCnt >= WW'(IN_WAKE)));
  assign clkGateEn = outValid || ((state == ST_WAKE) && (wakeCnt >= WW'(CLK_WAKE)));

  assign strb.idleClr = (state != ST_ACT);
  assign strb.passIn  = inGateEn;

  AST_VALID_AFTER_CLK: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> clkGateEn); // R6
  AST_CLK_AFTER_IN: assert property (@(posedge clk) disable iff (!rstN)
    clkGateEn |-> inGateEn); // R6
  AST_SBY_GATED: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (!inGateEn && !outValid)); // R7
  AST_SBY_HOLD_ACT: assert property (@(posedge clk) disable iff (!rstN)
    (standby && !pinMode && !stat.anyQual) |=> standby); // R3
  AST_SBY_HOLD_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (standby && pinMode && stat.pdHigh) |=> standby); // R10
  AST_PIN_NO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (pinMode && !stat.pdHigh && !standby) |=> !standby); // R10
endmodule

// File: rtl/sbyc_top.sv
module sbyc_top
  import sbyc_pkg::*;
#(
  parameter int NUM_IN    = 8,
  parameter int QUAL_CYC  = 3,
  parameter int IDLE_CYC  = 30,
  parameter int PD_HI_CYC = 8,
  parameter int PD_LO_CYC = 6,
  parameter int IN_WAKE   = 4,
  parameter int CLK_WAKE  = 6,
  parameter int OUT_WAKE  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinMode,
  input  logic              pdPin,
  input  logic [NUM_IN-1:0] dIn,
  output logic              standby,
  output logic              inGateEn,
  output logic              clkGateEn,
  output logic              outValid,
  output logic [NUM_IN-1:0] coreIn
);
  ctrlStrb_t strb;
  dpStat_t   stat;

  sbyc_datapath #(
    .NUM_IN(NUM_IN), .QUAL_CYC(QUAL_CYC), .IDLE_CYC(IDLE_CYC),
    .PD_HI_CYC(PD_HI_CYC), .PD_LO_CYC(PD_LO_CYC)
  ) uDp (
    .clk(clk), .rstN(rstN), .dIn(dIn), .pdPin(pdPin),
    .strb(strb), .stat(stat), .coreIn(coreIn)
  );

  sbyc_control #(
    .IN_WAKE(IN_WAKE), .CLK_WAKE(CLK_WAKE), .OUT_WAKE(OUT_WAKE)
  ) uCtl (
    .clk(clk), .rstN(rstN), .pinMode(pinMode), .stat(stat), .strb(strb),
    .standby(standby), .inGateEn(inGateEn), .clkGateEn(clkGateEn),
    .outValid(outValid)
  );
endmodule

// File: tb/tb_sbyc_top.sv
`timescale 1ns/1ps
module tb_sbyc_top;
  localparam int NUM_IN = 8, QUAL = 3, IDLE = 30, PDHI = 8, PDLO = 6;
  localparam int INW = 4, CLKW = 6, OUTW = 8;
  localparam logic [3:0] S_ACT = 4'b0111, S_SBY = 4'b1000, S_W0 = 4'b0000,
                         S_WIN = 4'b0100, S_WCLK = 4'b0110;

  logic clk = 1'b0, rstN = 1'b0, pinMode = 1'b0, pdPin = 1'b0;
  logic [NUM_IN-1:0] dIn = '0, coreIn;
  logic standby, inGateEn, clkGateEn, outValid;
  int cyc = 0, total = 0, bad = 0;

  typedef struct {
    int          due;
    string       req;
    logic [3:0]  st;
    bit          chkD;
    logic [7:0]  d;
  } exp_t;
  exp_t q[$];
  exp_t e;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sbyc_top #(.NUM_IN(NUM_IN), .QUAL_CYC(QUAL), .IDLE_CYC(IDLE), .PD_HI_CYC(PDHI),
             .PD_LO_CYC(PDLO), .IN_WAKE(INW), .CLK_WAKE(CLKW), .OUT_WAKE(OUTW)) dut (
    .clk(clk), .rstN(rstN), .pinMode(pinMode), .pdPin(pdPin), .dIn(dIn),
    .standby(standby), .inGateEn(inGateEn), .clkGateEn(clkGateEn),
    .outValid(outValid), .coreIn(coreIn));

  // driver side: queue an expectation rel edges from now
  task automatic expectAt(int rel, string req, logic [3:0] st, bit chkD, logic [7:0] d);
    exp_t x;
    x.due = cyc + rel; x.req = req; x.st = st; x.chkD = chkD; x.d = d;
    q.push_back(x);
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      total++;
      if ({standby, inGateEn, clkGateEn, outValid} !== e.st) begin
        bad++;
        $display("FAIL %s cyc=%0d status actual=%b expected=%b", e.req, cyc,
                 {standby, inGateEn, clkGateEn, outValid}, e.st);
      end else if (e.chkD && coreIn !== e.d) begin
        bad++;
        $display("FAIL %s cyc=%0d coreIn actual=%h expected=%h", e.req, cyc, coreIn, e.d);
      end
    end
  end

  task automatic doReset(bit mode);
    rstN = 1'b0; pinMode = mode; pdPin = 1'b0; dIn = '0;
    waitN(3);
    rstN = 1'b1;
  endtask

  initial begin
    // ---------- activity mode ----------
    doReset(1'b0);
    expectAt(1, "R1", S_ACT, 1, 8'h00);
    expectAt(IDLE, "R2", S_ACT, 0, 0);
    expectAt(IDLE + 1, "R2", S_SBY, 0, 0);
    waitN(IDLE + 4);
    // short glitch in standby must not wake
    expectAt(QUAL + 6, "R3", S_SBY, 1, 8'h00);
    dIn = 8'h5A; waitN(QUAL - 1); dIn = 8'h00;
    waitN(10);
    // qualified change wakes, staged release
    dIn = 8'h5A;
    expectAt(QUAL + 1, "R5", S_SBY, 1, 8'h00);
    expectAt(QUAL + 2, "R5", S_W0, 1, 8'h00);
    expectAt(QUAL + 2 + INW, "R6", S_WIN, 1, 8'h00);
    expectAt(QUAL + 3 + INW, "R7", S_WIN, 1, 8'h5A);
    expectAt(QUAL + 2 + CLKW, "R6", S_WCLK, 0, 0);
    expectAt(QUAL + 2 + OUTW, "R6", S_ACT, 0, 0);
    waitN(QUAL + 2 + OUTW);
    // glitch while active must not restart idle count
    expectAt(IDLE, "R3", S_ACT, 0, 0);
    expectAt(IDLE + 1, "R3", S_SBY, 1, 8'h5A);
    waitN(5);
    dIn = 8'hFF; waitN(QUAL - 1); dIn = 8'h5A;
    waitN(IDLE + 3 - 5 - (QUAL - 1));
    // wake again, then a qualified change restarts the idle count
    dIn = 8'h3C;
    waitN(QUAL + 2 + OUTW);
    waitN(10);
    dIn = 8'hC3;
    expectAt(3, "R7", S_ACT, 1, 8'hC3);
    expectAt(QUAL + 2 + IDLE, "R4", S_ACT, 0, 0);
    expectAt(QUAL + 3 + IDLE, "R4", S_SBY, 1, 8'hC3);
    waitN(QUAL + 5 + IDLE);

    // ---------- pin mode ----------
    doReset(1'b1);
    expectAt(1, "R1", S_ACT, 1, 8'h00);
    expectAt(IDLE + 10, "R10", S_ACT, 0, 0);
    waitN(IDLE + 10);
    expectAt(PDHI + 6, "R8", S_ACT, 0, 0);
    pdPin = 1'b1; waitN(PDHI - 1); pdPin = 1'b0;
    waitN(PDHI + 8);
    pdPin = 1'b1;
    expectAt(PDHI + 2, "R8", S_ACT, 0, 0);
    expectAt(PDHI + 3, "R8", S_SBY, 1, 8'h00);
    waitN(PDHI + 5);
    dIn = 8'h77;
    expectAt(QUAL + 10, "R10", S_SBY, 1, 8'h00);
    waitN(QUAL + 12);
    pdPin = 1'b0;
    expectAt(PDLO + 2, "R9", S_SBY, 1, 8'h00);
    expectAt(PDLO + 3, "R9", S_W0, 1, 8'h00);
    expectAt(PDLO + 3 + INW, "R9", S_WIN, 1, 8'h00);
    expectAt(PDLO + 4 + INW, "R9", S_WIN, 1, 8'h77);
    expectAt(PDLO + 3 + OUTW, "R9", S_ACT, 1, 8'h77);
    waitN(PDLO + 5 + OUTW);

    while (q.size() > 0) @(negedge clk);
    waitN(1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog cyc=%0d actual=hung expected=finished", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule